// File: doc/BRIEF.md
# Lane-Partitioned Concatenation Unit

This combinational block joins a wide data word with a narrow extension word when both are carved into the same SIMD lanes. The data word has three lanes of 4, 4 and 8 bits, counted from the least significant end. The extension word gives one bit to each lane. Two runtime partition enables say which lane boundaries are open. Lanes joined by a closed boundary merge into one group. For each group, the output holds the group's data bits in their original order, with the group's extension bits stacked directly above them.

Where a group's extension bits land therefore moves with the partition setting. The output is always as long as the two inputs together. A second output marks the least significant bit of every output group, so that a later stage can find the new lane boundaries without decoding the enables again. Lane widths, the extension width per lane and the lane count are parameters. The default configuration gives a 16-bit data word, a 3-bit extension word and a 19-bit result.

Top module: `pcat_top`

## Requirements
- R1: With both boundaries open (`seg_open_i` = 2'b11), `cat_o` is {b[2], a[15:8], b[1], a[7:4], b[0], a[3:0]}, which is three groups of 5, 5 and 9 bits from the LSB.
- R2: With only the boundary between lanes 0 and 1 closed (`seg_open_i` = 2'b10), `cat_o` is {b[2], a[15:8], b[1], b[0], a[7:0]}.
- R3: With only the boundary between lanes 1 and 2 closed (`seg_open_i` = 2'b01), `cat_o` is {b[2], b[1], a[15:4], b[0], a[3:0]}.
- R4: With both boundaries closed (`seg_open_i` = 2'b00), `cat_o` is {b[2:0], a[15:0]}.
- R5: Bit 0 of `seg_open_i` controls the boundary between lanes 0 and 1, and bit 1 controls the boundary between lanes 1 and 2. A 1 keeps the lanes apart; a 0 merges them.
- R6: Inside a merged group, the extension bits keep lane order: a lower lane's extension bit sits at a lower output position.
- R7: `cat_o` is a rearrangement of the input bits, so it holds exactly as many ones as `a_i` and `b_i` together.
- R8: `grp_lsb_o` has a 1 at the LSB position of each output group and 0 elsewhere. Bit 0 is always set. The number of ones is one more than the number of open boundaries, giving 19'h00421, 19'h00401, 19'h00021 and 19'h00001 for enables 11, 10, 01 and 00.
- R9: The block holds no state. Both outputs follow any change of the inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Data word: lane 0 in bits 3:0, lane 1 in bits 7:4, lane 2 in bits 15:8 |
| b_i | input | 3 | Extension word, one bit per lane; bit i belongs to lane i |
| seg_open_i | input | 2 | Boundary enables; bit i is the boundary above lane i, and 1 means open |
| cat_o | output | 19 | Concatenated result, group by group |
| grp_lsb_o | output | 19 | One-hot-per-group marker of each group's LSB position |

## Verification
The assertions check, on every input change, that the result holds the same number of ones as the inputs, that the group marker always has bit 0 set and one bit per group, that the fully merged setting yields the plain concatenation, and that each lane's group span encloses the lane. The exact position of every bit under each of the four enable settings, and the lane order of the extension bits inside merged groups, can only be shown by the bench's scenarios. These scenarios cover directed words with hand-written expected concatenations and random words checked against a queue-based model that builds the groups one at a time.

// File: rtl/pcat_pkg.sv
// pcat_pkg: shared types and helpers for the lane-partitioned concatenation unit.
// Assumes no configuration uses more than MAX_LANES lanes.
package pcat_pkg;

    localparam int MAX_LANES = 8;

    // Per-lane data widths; entries at and beyond the lane count are ignored.
    typedef int unsigned width_list_t [MAX_LANES];

    // Bit offset of lane n inside the data word (sum of the widths below it).
    function automatic int lane_base(width_list_t w, int n);
        int s;
        s = 0;
        for (int j = 0; j < MAX_LANES; j++) begin
            if (j < n) s += int'(w[j]);
        end
        return s;
    endfunction

    // Index width for lane numbers, never below one bit.
    function automatic int idx_bits(int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/pcat_span.sv
// pcat_span: for each lane, finds the lowest and highest lane of the group
// that contains it, from the boundary-open enables.
// Assumes a 1 enable bit means the boundary above that lane is open.
module pcat_span
    import pcat_pkg::*;
#(
    parameter int NUM_LANES = 3,
    localparam int IDX_W = idx_bits(NUM_LANES)
) (
    input  logic [NUM_LANES-2:0]            seg_open_i,
    output logic [NUM_LANES-1:0][IDX_W-1:0] first_o,
    output logic [NUM_LANES-1:0][IDX_W-1:0] last_o
);

    // Sweep upward: a group starts at lane 0 or just above an open boundary.
    always_comb begin
        logic [IDX_W-1:0] run;
        run = '0;
        first_o[0] = '0;
        for (int i = 1; i < NUM_LANES; i++) begin
            if (seg_open_i[i-1]) run = IDX_W'(i);
            first_o[i] = run;
        end
    end

    // Sweep downward: a group ends at the top lane or just below an open boundary.
    always_comb begin
        logic [IDX_W-1:0] run;
        run = IDX_W'(NUM_LANES - 1);
        last_o[NUM_LANES-1] = run;
        for (int i = NUM_LANES - 2; i >= 0; i--) begin
            if (seg_open_i[i]) run = IDX_W'(i);
            last_o[i] = run;
        end
    end

    // Each lane must lie inside the span reported for it.
    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            AST_SPAN_ENCLOSES: assert (int'(first_o[i]) <= i && int'(last_o[i]) >= i)
                else $error("lane %0d span %0d..%0d", i, first_o[i], last_o[i]); // R5
        end
    end

endmodule

// File: rtl/pcat_route.sv
// pcat_route: places each lane's data bits and extension bits in the output.
// A lane's data shifts up by EXT_W for every lane below its group's start.
// A lane's extension bits sit above the data of its whole group, in lane order.
// Assumes spans come from pcat_span for the same enables.
module pcat_route
    import pcat_pkg::*;
#(
    parameter int          NUM_LANES = 3,
    parameter int          EXT_W     = 1,
    parameter width_list_t LANE_AW   = '{4, 4, 8, 0, 0, 0, 0, 0},
    localparam int IDX_W = idx_bits(NUM_LANES),
    localparam int A_W   = lane_base(LANE_AW, NUM_LANES),
    localparam int B_W   = NUM_LANES * EXT_W,
    localparam int OUT_W = A_W + B_W
) (
    input  logic [A_W-1:0]                  a_i,
    input  logic [B_W-1:0]                  b_i,
    input  logic [NUM_LANES-1:0][IDX_W-1:0] first_i,
    input  logic [NUM_LANES-1:0][IDX_W-1:0] last_i,
    output logic [OUT_W-1:0]                cat_o
);

    // Gather every lane's two pieces into their group positions.
    always_comb begin
        logic [A_W-1:0]   amask;
        logic [OUT_W-1:0] seg;
        int               base;
        int               top;
        cat_o = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            base  = lane_base(LANE_AW, i);
            amask = {A_W{1'b1}} >> (A_W - int'(LANE_AW[i]));
            seg   = OUT_W'((a_i >> base) & amask);
            cat_o = cat_o | (seg << (base + int'(first_i[i]) * EXT_W));
            top   = lane_base(LANE_AW, int'(last_i[i]) + 1);
            seg   = OUT_W'((b_i >> (i * EXT_W)) & B_W'({EXT_W{1'b1}}));
            cat_o = cat_o | (seg << (top + i * EXT_W));
        end
    end

    // Routing only moves bits; none are lost or duplicated.
    always_comb begin
        AST_BIT_CONSERVE: assert ($countones(cat_o) == $countones(a_i) + $countones(b_i))
            else $error("ones out %0d in %0d", $countones(cat_o),
                        $countones(a_i) + $countones(b_i)); // R7
    end

endmodule

// File: rtl/pcat_mark.sv
// pcat_mark: raises one output bit at the LSB position of every group.
// Works from the enables directly, independent of the data routing.
module pcat_mark
    import pcat_pkg::*;
#(
    parameter int          NUM_LANES = 3,
    parameter int          EXT_W     = 1,
    parameter width_list_t LANE_AW   = '{4, 4, 8, 0, 0, 0, 0, 0},
    localparam int OUT_W = lane_base(LANE_AW, NUM_LANES) + NUM_LANES * EXT_W
) (
    input  logic [NUM_LANES-2:0] seg_open_i,
    output logic [OUT_W-1:0]     grp_lsb_o
);

    logic [NUM_LANES-1:0] starts;

    // Lane 0 always opens a group; other lanes open one above an open boundary.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_start
        if (g == 0) begin : g_base
            assign starts[g] = 1'b1;
        end else begin : g_upper
            assign starts[g] = seg_open_i[g-1];
        end
    end

    // A group starting at lane i begins after all lower data and extension bits.
    always_comb begin
        grp_lsb_o = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            grp_lsb_o = grp_lsb_o |
                (OUT_W'(starts[i]) << (lane_base(LANE_AW, i) + i * EXT_W));
        end
    end

endmodule

// File: rtl/pcat_top.sv
// pcat_top: lane-partitioned concatenation of a data word and an extension word.
// Purely combinational. Spans, routing and group markers are built in separate
// submodules. Assumes at least two lanes.
module pcat_top
    import pcat_pkg::*;
#(
    parameter int          NUM_LANES = 3,
    parameter int          EXT_W     = 1,
    parameter width_list_t LANE_AW   = '{4, 4, 8, 0, 0, 0, 0, 0},
    localparam int IDX_W = idx_bits(NUM_LANES),
    localparam int A_W   = lane_base(LANE_AW, NUM_LANES),
    localparam int B_W   = NUM_LANES * EXT_W,
    localparam int OUT_W = A_W + B_W
) (
    input  logic [A_W-1:0]       a_i,
    input  logic [B_W-1:0]       b_i,
    input  logic [NUM_LANES-2:0] seg_open_i,
    output logic [OUT_W-1:0]     cat_o,
    output logic [OUT_W-1:0]     grp_lsb_o
);

    logic [NUM_LANES-1:0][IDX_W-1:0] first;
    logic [NUM_LANES-1:0][IDX_W-1:0] last;

    pcat_span #(.NUM_LANES(NUM_LANES)) u_span (
        .seg_open_i (seg_open_i),
        .first_o    (first),
        .last_o     (last)
    );

    pcat_route #(.NUM_LANES(NUM_LANES), .EXT_W(EXT_W), .LANE_AW(LANE_AW)) u_route (
        .a_i     (a_i),
        .b_i     (b_i),
        .first_i (first),
        .last_i  (last),
        .cat_o   (cat_o)
    );

    pcat_mark #(.NUM_LANES(NUM_LANES), .EXT_W(EXT_W), .LANE_AW(LANE_AW)) u_mark (
        .seg_open_i (seg_open_i),
        .grp_lsb_o  (grp_lsb_o)
    );

    // Marker and routing agree: one group per open boundary plus one.
    // Full merge gives the plain concatenation.
    always_comb begin
        AST_LSB_MARKED: assert (grp_lsb_o[0])
            else $error("group marker lost bit 0"); // R8
        AST_GROUP_COUNT: assert ($countones(grp_lsb_o) == $countones(seg_open_i) + 1)
            else $error("marker ones %0d", $countones(grp_lsb_o)); // R8
        if (seg_open_i == '0) begin
            AST_FULL_MERGE: assert (cat_o == {b_i, a_i})
                else $error("merged result %h", cat_o); // R4
        end
    end

endmodule

// File: tb/sim_pcat_top.sv
// sim_pcat_top: directed and random checks of pcat_top against hand-written
// concatenations and a queue-based group-by-group model.
module sim_pcat_top;

    localparam int PERIOD = 10;

    logic        clk;
    logic [15:0] a;
    logic [2:0]  b;
    logic [1:0]  pt;
    logic [18:0] cat;
    logic [18:0] mark;
    int          n_total;
    int          n_fail;

    pcat_top u0 (
        .a_i        (a),
        .b_i        (b),
        .seg_open_i (pt),
        .cat_o      (cat),
        .grp_lsb_o  (mark)
    );

    // Free-running clock for pacing stimulus and sampling.
    initial begin
        clk = 1'b0;
        forever #(PERIOD / 2) clk = ~clk;
    end

    // Record one comparison and report a mismatch.
    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%b pt=%b)", tag, act, exp, a, b, pt);
        end
    endtask

    // Reference: walk lanes, close each group, push data bits then extension bits.
    function automatic void ref_model(input logic [15:0] ra, input logic [2:0] rb,
                                      input logic [1:0] rpt,
                                      output logic [18:0] rc, output logic [18:0] rm);
        int w[3];
        bit q[$];
        int lane;
        int ap;
        w = '{4, 4, 8};
        lane = 0;
        ap = 0;
        rc = '0;
        rm = '0;
        while (lane < 3) begin
            int hi;
            hi = lane;
            while (hi < 2 && !rpt[hi]) hi++;
            rm[q.size()] = 1'b1;
            for (int l = lane; l <= hi; l++) begin
                for (int k = 0; k < w[l]; k++) begin
                    q.push_back(ra[ap]);
                    ap++;
                end
            end
            for (int l = lane; l <= hi; l++) q.push_back(rb[l]);
            lane = hi + 1;
        end
        for (int k = 0; k < q.size(); k++) rc[k] = q[k];
    endfunction

    // Apply inputs at a rising edge; sample at the following falling edge.
    task automatic apply(input logic [15:0] na, input logic [2:0] nb, input logic [1:0] np);
        @(posedge clk);
        a  = na;
        b  = nb;
        pt = np;
        @(negedge clk);
    endtask

    // Ends a hung run as a failure.
    initial begin
        #(PERIOD * 150000);
        n_total++;
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    // Main stimulus sequence.
    initial begin
        logic [18:0] ec;
        logic [18:0] em;
        n_total = 0;
        n_fail  = 0;
        a  = '0;
        b  = '0;
        pt = 2'b11;

        // Idle state: zero inputs give zero data and the three-group marker.
        @(negedge clk);
        check("R7 idle data", cat, 19'h0);
        check("R8 idle marker", mark, 19'h00421);

        // R1: all boundaries open.
        apply(16'hA5C3, 3'b101, 2'b11);
        check("R1 all open", cat, {b[2], a[15:8], b[1], a[7:4], b[0], a[3:0]});
        check("R8 marker 11", mark, 19'h00421);

        // R2 and R6: lanes 0 and 1 merged.
        apply(16'h3C96, 3'b001, 2'b10);
        check("R2 low merged", cat, {b[2], a[15:8], b[1], b[0], a[7:0]});
        check("R6 low group ext order", cat[9:8], 2'b01);
        check("R8 marker 10", {13'h0, mark[18:13]} | (mark & 19'h01FFF), 19'h00401);

        // R3 and R6: lanes 1 and 2 merged.
        apply(16'h7E21, 3'b010, 2'b01);
        check("R3 high merged", cat, {b[2], b[1], a[15:4], b[0], a[3:0]});
        check("R6 high group ext order", cat[18:17], 2'b01);
        check("R8 marker 01", mark, 19'h00021);

        // R4: everything merged; R6 order of all three extension bits.
        apply(16'hBEEF, 3'b110, 2'b00);
        check("R4 all merged", cat, {b, a});
        check("R6 full ext order", cat[18:16], 3'b110);
        check("R8 marker 00", mark, 19'h00001);

        // R5: the same data under swapped enables lands differently per bit meaning.
        apply(16'h00F0, 3'b000, 2'b10);
        check("R5 enable bit0 merges lanes 0-1", cat, 19'h000F0);
        apply(16'h00F0, 3'b000, 2'b01);
        check("R5 enable bit1 merges lanes 1-2", cat, 19'h001E0);

        // R9: output follows inputs without any clock edge.
        @(posedge clk);
        #1;
        a = 16'h1234; b = 3'b111; pt = 2'b11;
        #1;
        check("R9 first change", cat, {1'b1, 8'h12, 1'b1, 4'h3, 1'b1, 4'h4});
        a = 16'hFFFF; b = 3'b000; pt = 2'b00;
        #1;
        check("R9 second change", cat, 19'h0FFFF);

        // R1-style random sweep over every enable setting against the model.
        for (int cyc = 0; cyc < 400; cyc++) begin
            logic [15:0] ra;
            logic [2:0]  rb;
            ra = 16'($urandom);
            rb = 3'($urandom);
            apply(ra, rb, 2'(cyc % 4));
            ref_model(ra, rb, 2'(cyc % 4), ec, em);
            case (cyc % 4)
                0:       check("R4 random", cat, ec);
                1:       check("R3 random", cat, ec);
                2:       check("R2 random", cat, ec);
                default: check("R1 random", cat, ec);
            endcase
            check("R8 random marker", mark, em);
            check("R7 random ones", 19'($countones(cat)), 19'($countones(ra) + $countones(rb)));
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule